// File: doc/BRIEF.md
# Paged Program-Memory Self-Programming Controller

This block lets a processor rewrite its own paged program memory. Software first writes a command into an 8-bit control/status register. It then issues a store strobe together with a 16-bit pointer and a 16-bit data word. The controller splits the pointer into a page number and a word-in-page index. It then does one of three things: fills one word of a temporary page buffer, erases a whole page to all ones, or copies the buffer into a page. Erase and write take a fixed number of cycles, set by a parameter. The memory array is modelled as a small register array.

The lower pages form the read-while-write section. Starting an erase or write on one of these pages raises a busy flag. While the flag is set, reads of that section return all ones. The flag stays set after the operation ends. It is cleared only by a re-enable command or by the next buffer load. A ready interrupt is raised when the local enable is set, the global enable is set and no command is armed.

The sequencer has five states:
- IDLE waits for an armed store strobe.
- FILL lasts one cycle and ends a buffer load.
- MISC lasts one cycle and ends a re-enable or lock-bit command.
- ERASE counts down the operation latency, then erases the page.
- PROG counts down the operation latency, then writes the page.

The transitions are:
- IDLE goes to FILL, ERASE, PROG or MISC on an accepted strobe, depending on the command bits.
- FILL and MISC go back to IDLE after one cycle.
- ERASE and PROG go back to IDLE when their counter expires.

Top module: `flash_selfprog`

## Requirements
- R1: After reset, csr_rdata reads 0x00, irq is low and every array word reads 0xFFFF.
- R2: The word-in-page index is spm_ptr[6:1]. The page number is spm_ptr[13:7], reduced to its low log2(NUM_PAGES) bits. Bits 15:14 have no effect, and rd_ptr is decoded the same way.
- R3: Set bit 0 (arm) alone in the register and pulse spm_go. The data word is stored into the buffer at the indexed word. Bit 0 reads 1 in the cycle after the strobe edge and 0 one cycle later.
- R4: Write 0x05 (bit 2, write, plus arm) and pulse spm_go with word index 0. Bits 0 and 2 stay set for OP_CYCLES edges after the strobe edge, then clear. At that point the page holds the buffer, and the buffer is all ones.
- R5: Write 0x03 (bit 1, erase, plus arm) and pulse spm_go. After OP_CYCLES edges every word of the page reads 0xFFFF and bits 0 and 1 clear.
- R6: An erase or write on a page below RWW_PAGES sets bit 6 (busy) on the strobe edge. The same operation on a higher page leaves bit 6 clear.
- R7: While bit 6 is set, rd_data is 0xFFFF for pages below RWW_PAGES. Higher pages read their stored contents.
- R8: Bit 6 stays set after the operation finishes. An accepted strobe with 0x11 (bit 4, re-enable, plus arm) clears it on the strobe edge.
- R9: An accepted buffer load clears bit 6 on the strobe edge.
- R10: irq equals bit 7 AND gie AND NOT bit 0.
- R11: The following strobes are ignored: one with spm_ptr[0]=1, one given while bit 0 is clear, and a page write whose word index is nonzero. In each case the register and the array are left unchanged.
- R12: While an operation runs, a register write changes only bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Control register: bit 7 int enable, 6 busy, 4 re-enable, 3 lock-bit, 2 write, 1 erase, 0 arm |
| gie | input | 1 | Global interrupt enable |
| spm_go | input | 1 | Store-to-program-memory strobe |
| spm_ptr | input | 16 | Store pointer (byte select, word index, page) |
| spm_data | input | 16 | Data word for a buffer load |
| rd_ptr | input | 16 | Read pointer, decoded like spm_ptr |
| rd_data | output | 16 | Read data from the array |
| irq | output | 1 | Ready interrupt request |

## Verification
Register writes, buffer loads and busy-flag changes appear one edge after the strobe. The arm bit of a load clears one edge later than that. Erase and write results, and the clearing of the command bits, appear exactly OP_CYCLES edges after the strobe edge. The read blocking and irq respond combinationally to the current state. Each scenario task drives inputs on the falling edge and counts rising edges from the strobe. It checks the register one edge before a result is due to see the command still armed, and again at the edge where the result is due. It reads the array only after the required number of edges.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    localparam int PTR_W     = 16;
    localparam int DATA_W    = 16;
    localparam int PAGE_MSB  = 13;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL  = 3'd1,
        ST_ERASE = 3'd2,
        ST_PROG  = 3'd3,
        ST_MISC  = 3'd4
    } state_e;

    typedef enum logic [2:0] {
        CMD_LOAD  = 3'd0,
        CMD_ERASE = 3'd1,
        CMD_PROG  = 3'd2,
        CMD_REEN  = 3'd3,
        CMD_MISC  = 3'd4
    } cmd_e;

endpackage

// File: rtl/fsp_ptr_dec.sv
module fsp_ptr_dec
    import fsp_pkg::*;
#(
    parameter int PAGE_WORDS = 64,
    parameter int NUM_PAGES  = 4
) (
    input  logic [PTR_W-1:0]                 ptr,
    output logic                             byte_sel,
    output logic [$clog2(PAGE_WORDS)-1:0]    word_idx,
    output logic [$clog2(NUM_PAGES)-1:0]     page_idx
);
    localparam int WAW = $clog2(PAGE_WORDS);
    localparam int PIW = $clog2(NUM_PAGES);
    localparam int PLO = WAW + 1;

    logic unused_hi;

    assign byte_sel  = ptr[0];
    assign word_idx  = ptr[WAW:1];
    assign page_idx  = ptr[PLO + PIW - 1:PLO];
    assign unused_hi = ^ptr[PTR_W-1:PLO + PIW];
endmodule

// File: rtl/fsp_page_buf.sv
module fsp_page_buf
    import fsp_pkg::*;
#(
    parameter int PAGE_WORDS = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_en,
    input  logic [$clog2(PAGE_WORDS)-1:0]     load_idx,
    input  logic [DATA_W-1:0]                 load_data,
    input  logic                              clr,
    output logic [PAGE_WORDS*DATA_W-1:0]      flat
);
    logic [DATA_W-1:0] words [PAGE_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_WORDS; i++) words[i] <= '1;
        end else if (clr) begin
            for (int i = 0; i < PAGE_WORDS; i++) words[i] <= '1;
        end else if (load_en) begin
            words[load_idx] <= load_data;
        end
    end

    for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_flat
        assign flat[g*DATA_W +: DATA_W] = words[g];
    end
endmodule

// File: rtl/fsp_array.sv
module fsp_array
    import fsp_pkg::*;
#(
    parameter int PAGE_WORDS = 64,
    parameter int NUM_PAGES  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              erase_en,
    input  logic                              prog_en,
    input  logic [$clog2(NUM_PAGES)-1:0]      op_page,
    input  logic [PAGE_WORDS*DATA_W-1:0]      buf_flat,
    input  logic [$clog2(NUM_PAGES)-1:0]      rd_page,
    input  logic [$clog2(PAGE_WORDS)-1:0]     rd_word,
    output logic [DATA_W-1:0]                 rd_val
);
    logic [DATA_W-1:0] cells [NUM_PAGES][PAGE_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++)
                for (int w = 0; w < PAGE_WORDS; w++)
                    cells[p][w] <= '1;
        end else if (erase_en) begin
            for (int w = 0; w < PAGE_WORDS; w++) cells[op_page][w] <= '1;
        end else if (prog_en) begin
            for (int w = 0; w < PAGE_WORDS; w++)
                cells[op_page][w] <= buf_flat[w*DATA_W +: DATA_W];
        end
    end

    assign rd_val = cells[rd_page][rd_word];
endmodule

// File: rtl/flash_selfprog.sv
module flash_selfprog
    import fsp_pkg::*;
#(
    parameter int PAGE_WORDS = 64,
    parameter int NUM_PAGES  = 4,
    parameter int RWW_PAGES  = 2,
    parameter int OP_CYCLES  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_we,
    input  logic [7:0]          csr_wdata,
    output logic [7:0]          csr_rdata,
    input  logic                gie,
    input  logic                spm_go,
    input  logic [PTR_W-1:0]    spm_ptr,
    input  logic [DATA_W-1:0]   spm_data,
    input  logic [PTR_W-1:0]    rd_ptr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq
);
    localparam int WAW = $clog2(PAGE_WORDS);
    localparam int PIW = $clog2(NUM_PAGES);
    localparam int CW  = $clog2(OP_CYCLES + 1);
    localparam logic [PIW:0]  RWW_LIM  = (PIW+1)'(RWW_PAGES);
    localparam logic [CW-1:0] CNT_INIT = CW'(OP_CYCLES - 1);

    state_e state_q, state_d;
    cmd_e   cmd;

    logic ie_q, busy_q, reen_q, lock_q, wr_q, er_q, arm_q;
    logic [CW-1:0]  cnt_q;
    logic [PIW-1:0] op_page_q;

    logic           s_bsel, r_unused_bsel;
    logic [WAW-1:0] s_word, r_word;
    logic [PIW-1:0] s_page, r_page;
    logic           s_rww, r_rww;
    logic           go_ok, start_ok, cnt_zero, done;
    logic           buf_we, buf_clr, arr_erase, arr_prog;
    logic [PAGE_WORDS*DATA_W-1:0] buf_flat;
    logic [DATA_W-1:0] arr_rd;

    fsp_ptr_dec #(.PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)) u_spm_dec (
        .ptr(spm_ptr), .byte_sel(s_bsel), .word_idx(s_word), .page_idx(s_page));

    fsp_ptr_dec #(.PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)) u_rd_dec (
        .ptr(rd_ptr), .byte_sel(r_unused_bsel), .word_idx(r_word), .page_idx(r_page));

    assign s_rww    = {1'b0, s_page} < RWW_LIM;
    assign r_rww    = {1'b0, r_page} < RWW_LIM;
    assign cnt_zero = (cnt_q == '0);

    // command selection from armed register bits
    always_comb begin
        if (er_q)        cmd = CMD_ERASE;
        else if (wr_q)   cmd = CMD_PROG;
        else if (reen_q) cmd = CMD_REEN;
        else if (lock_q) cmd = CMD_MISC;
        else             cmd = CMD_LOAD;
    end

    assign go_ok    = (state_q == ST_IDLE) && spm_go && arm_q && !s_bsel;
    assign start_ok = go_ok && !((cmd == CMD_PROG) && (s_word != '0));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    unique case (cmd)
                        CMD_LOAD:  state_d = ST_FILL;
                        CMD_ERASE: state_d = ST_ERASE;
                        CMD_PROG:  state_d = ST_PROG;
                        CMD_REEN,
                        CMD_MISC:  state_d = ST_MISC;
                        default:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_FILL, ST_MISC:  state_d = ST_IDLE;
            ST_ERASE, ST_PROG: if (cnt_zero) state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    // output strobes
    always_comb begin
        buf_we    = start_ok && (cmd == CMD_LOAD);
        arr_erase = (state_q == ST_ERASE) && cnt_zero;
        arr_prog  = (state_q == ST_PROG) && cnt_zero;
        buf_clr   = arr_prog;
        done      = (state_q == ST_FILL) || (state_q == ST_MISC) || arr_erase || arr_prog;
    end

    // register file, counter and busy flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= 1'b0; busy_q <= 1'b0; reen_q <= 1'b0; lock_q <= 1'b0;
            wr_q <= 1'b0; er_q <= 1'b0;   arm_q <= 1'b0;
            cnt_q <= '0;  op_page_q <= '0;
        end else begin
            if (csr_we) begin
                ie_q <= csr_wdata[7];
                if (state_q == ST_IDLE && !spm_go) begin
                    reen_q <= csr_wdata[4];
                    lock_q <= csr_wdata[3];
                    wr_q   <= csr_wdata[2];
                    er_q   <= csr_wdata[1];
                    arm_q  <= csr_wdata[0];
                end
            end
            if (start_ok) begin
                cnt_q     <= CNT_INIT;
                op_page_q <= s_page;
                if ((cmd == CMD_ERASE || cmd == CMD_PROG) && s_rww) busy_q <= 1'b1;
                if (cmd == CMD_LOAD || cmd == CMD_REEN)             busy_q <= 1'b0;
            end else if ((state_q == ST_ERASE || state_q == ST_PROG) && !cnt_zero) begin
                cnt_q <= cnt_q - CW'(1);
            end
            if (done) begin
                reen_q <= 1'b0; lock_q <= 1'b0; wr_q <= 1'b0;
                er_q   <= 1'b0; arm_q  <= 1'b0;
            end
        end
    end

    fsp_page_buf #(.PAGE_WORDS(PAGE_WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .load_en(buf_we), .load_idx(s_word),
        .load_data(spm_data), .clr(buf_clr), .flat(buf_flat));

    fsp_array #(.PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)) u_arr (
        .clk(clk), .rst_n(rst_n), .erase_en(arr_erase), .prog_en(arr_prog),
        .op_page(op_page_q), .buf_flat(buf_flat), .rd_page(r_page),
        .rd_word(r_word), .rd_val(arr_rd));

    assign csr_rdata = {ie_q, busy_q, 1'b0, reen_q, lock_q, wr_q, er_q, arm_q};
    assign irq       = ie_q & gie & ~arm_q;
    assign rd_data   = (busy_q && r_rww) ? '1 : arr_rd;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker
    import fsp_pkg::*;
#(
    parameter int PAGE_WORDS = 64,
    parameter int NUM_PAGES  = 4,
    parameter int RWW_PAGES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input state_e            state,
    input logic [7:0]        csr_rdata,
    input logic              gie,
    input logic              irq,
    input logic              spm_go,
    input logic [PTR_W-1:0]  spm_ptr,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic [DATA_W-1:0] rd_data
);
    localparam int WAW = $clog2(PAGE_WORDS);
    localparam int PIW = $clog2(NUM_PAGES);
    localparam logic [PIW:0] LIM = (PIW+1)'(RWW_PAGES);

    logic rd_in_rww;
    assign rd_in_rww = {1'b0, rd_ptr[WAW+PIW:WAW+1]} < LIM;

    AST_FILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |=> (state == ST_IDLE && !csr_rdata[0])); // R3
    AST_ARM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> csr_rdata[0]); // R4
    AST_BUSY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rdata[6]) |-> ($past(spm_go) && $past(state == ST_IDLE))); // R6
    AST_BUSY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_rdata[6]) |-> ($past(spm_go) && $past(state == ST_IDLE))); // R8
    AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[6] && rd_in_rww) |-> (rd_data == '1)); // R7
    AST_IRQ_GATING: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (csr_rdata[7] && gie && !csr_rdata[0])); // R10
    AST_ODD_PTR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && spm_go && spm_ptr[0]) |=> (state == ST_IDLE)); // R11
endmodule

bind flash_selfprog fsp_checker #(
    .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES), .RWW_PAGES(RWW_PAGES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .csr_rdata(csr_rdata),
    .gie(gie), .irq(irq), .spm_go(spm_go), .spm_ptr(spm_ptr),
    .rd_ptr(rd_ptr), .rd_data(rd_data)
);

// File: tb/flash_selfprog_test.sv
module flash_selfprog_test;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [7:0]  csr_wdata = '0;
    logic [7:0]  csr_rdata;
    logic        gie = 1'b0;
    logic        spm_go = 1'b0;
    logic [15:0] spm_ptr = '0;
    logic [15:0] spm_data = '0;
    logic [15:0] rd_ptr = '0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flash_selfprog #(.PAGE_WORDS(64), .NUM_PAGES(4), .RWW_PAGES(2), .OP_CYCLES(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .gie(gie), .spm_go(spm_go), .spm_ptr(spm_ptr),
        .spm_data(spm_data), .rd_ptr(rd_ptr), .rd_data(rd_data), .irq(irq));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ptr_of(input int page, input int word);
        return 16'((page << 7) | (word << 1));
    endfunction

    function automatic logic [15:0] pat_a(input int i);
        return 16'(16'h3C00 + i * 7);
    endfunction

    function automatic logic [15:0] pat_b(input int i);
        return {8'h5A, 8'(i * 3)};
    endfunction

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_csr(input logic [7:0] v);
        csr_we = 1'b1; csr_wdata = v;
        edges(1);
        csr_we = 1'b0;
    endtask

    task automatic strobe(input logic [15:0] p, input logic [15:0] d);
        spm_go = 1'b1; spm_ptr = p; spm_data = d;
        edges(1);
        spm_go = 1'b0;
    endtask

    task automatic load_word(input logic [15:0] p, input logic [15:0] d);
        write_csr(8'h01);
        strobe(p, d);
        edges(1);
    endtask

    task automatic read_page(input string req, input int page, input bit use_a, input bit ones);
        int bad = 0;
        logic [15:0] exp;
        for (int w = 0; w < 64; w++) begin
            rd_ptr = ptr_of(page, w);
            #1;
            exp = ones ? 16'hFFFF : (use_a ? pat_a(w) : pat_b(w));
            if (rd_data !== exp && bad == 0) begin
                check(req, rd_data, exp);
                bad = 1;
            end
        end
        if (bad == 0) check(req, exp, exp);
    endtask

    task automatic t_reset;
        check("R1 csr", {8'h0, csr_rdata}, 16'h0000);
        check("R1 irq", {15'h0, irq}, 16'h0000);
        rd_ptr = ptr_of(2, 9); #1;
        check("R1 array", rd_data, 16'hFFFF);
    endtask

    task automatic t_load_and_write_hi;
        write_csr(8'h01);
        strobe(16'hC000 | ptr_of(0, 0), pat_a(0));
        check("R3 arm held", {8'h0, csr_rdata}, 16'h0001);
        edges(1);
        check("R3 arm cleared", {8'h0, csr_rdata}, 16'h0000);
        for (int w = 1; w < 64; w++)
            load_word(((w % 2) != 0 ? 16'h8000 : 16'h0000) | ptr_of(0, w), pat_a(w));
        write_csr(8'h05);
        strobe(16'h4000 | ptr_of(3, 0), 16'h0);
        check("R6 no busy on upper page", {15'h0, csr_rdata[6]}, 16'h0000);
        edges(LAT - 1);
        check("R4 still armed", {8'h0, csr_rdata}, 16'h0005);
        edges(1);
        check("R4 bits cleared", {8'h0, csr_rdata}, 16'h0000);
        read_page("R4 R2 page3 = buffer", 3, 1'b1, 1'b0);
        rd_ptr = 16'hC000 | ptr_of(3, 5); #1;
        check("R2 top bits ignored on read", rd_data, pat_a(5));
    endtask

    task automatic t_write_rww;
        for (int w = 0; w < 64; w++) load_word(ptr_of(1, w), pat_b(w));
        write_csr(8'h05);
        strobe(ptr_of(1, 0), 16'h0);
        check("R6 busy set", {15'h0, csr_rdata[6]}, 16'h0001);
        rd_ptr = ptr_of(3, 4); #1;
        check("R7 upper page readable", rd_data, pat_a(4));
        write_csr(8'h80);
        check("R12 only bit7 changes", {8'h0, csr_rdata}, 16'h00C5);
        edges(LAT - 2);
        write_csr(8'h00);
        check("R4 complete", {8'h0, csr_rdata}, 16'h0040);
        read_page("R7 busy section blocked", 1, 1'b0, 1'b1);
        write_csr(8'h11);
        strobe(16'h0, 16'h0);
        check("R8 re-enable clears busy", {15'h0, csr_rdata[6]}, 16'h0000);
        edges(1);
        read_page("R4 page1 = buffer", 1, 1'b0, 1'b0);
    endtask

    task automatic t_buffer_reset;
        write_csr(8'h05);
        strobe(ptr_of(3, 0), 16'h0);
        edges(LAT);
        read_page("R4 buffer reset to ones", 3, 1'b0, 1'b1);
    endtask

    task automatic t_erase;
        write_csr(8'h03);
        strobe(ptr_of(1, 0), 16'h0);
        check("R6 busy on erase", {15'h0, csr_rdata[6]}, 16'h0001);
        edges(LAT - 1);
        check("R5 erase armed", {8'h0, csr_rdata}, 16'h0043);
        edges(1);
        check("R5 erase bits cleared", {8'h0, csr_rdata}, 16'h0040);
        load_word(ptr_of(0, 7), 16'h1234);
        check("R9 load clears busy", {15'h0, csr_rdata[6]}, 16'h0000);
        read_page("R5 page1 erased", 1, 1'b0, 1'b1);
    endtask

    task automatic t_reject;
        write_csr(8'h01);
        strobe(ptr_of(0, 2) | 16'h0001, 16'hBEEF);
        edges(2);
        check("R11 odd pointer ignored", {8'h0, csr_rdata}, 16'h0001);
        write_csr(8'h05);
        strobe(ptr_of(3, 5), 16'h0);
        edges(LAT + 1);
        check("R11 write with word index ignored", {8'h0, csr_rdata}, 16'h0005);
        rd_ptr = ptr_of(3, 7); #1;
        check("R11 page unchanged", rd_data, 16'hFFFF);
        write_csr(8'h04);
        strobe(ptr_of(3, 0), 16'h0);
        edges(LAT + 1);
        check("R11 unarmed strobe ignored", {8'h0, csr_rdata}, 16'h0004);
        rd_ptr = ptr_of(3, 7); #1;
        check("R11 page unchanged unarmed", rd_data, 16'hFFFF);
        write_csr(8'h00);
    endtask

    task automatic t_irq;
        gie = 1'b1;
        write_csr(8'h80);
        check("R10 irq high", {15'h0, irq}, 16'h0001);
        write_csr(8'h81);
        check("R10 irq low when armed", {15'h0, irq}, 16'h0000);
        strobe(ptr_of(0, 1), 16'h0);
        edges(1);
        check("R10 irq after load", {15'h0, irq}, 16'h0001);
        gie = 1'b0; #1;
        check("R10 irq gated by gie", {15'h0, irq}, 16'h0000);
    endtask

    initial begin
        edges(2);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_load_and_write_hi();
        t_write_rww();
        t_buffer_reset();
        t_erase();
        t_reject();
        t_irq();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule